// File: doc/BRIEF.md
# Two-Bus Datapath Sequencer

This block is a small register datapath. Three storage registers (X, Y, Z), a temporary operand register T and an ALU are joined by two shared buses. A single read bus carries one register value per control step to the right-hand ALU input. The left-hand ALU input is always T. A write bus carries the ALU result back to the storage registers. A controller accepts one command at a time through a valid/ready handshake. A command names a left source, a right source, a destination and an opcode.

Because only one register can drive the read bus in a step, a two-operand command is split into two control steps. The first step copies the left source into T. The second step places the right source on the bus, combines it with T and stores the result. A one-operand command (bitwise NOT of the right source) skips the T step. Register contents are visible on output ports, so software-free stimulus can build any value from the reset state using NOT and ADD.

Top module: `twobus_seq`

## Requirements
- R1: A synchronous active-high reset clears X, Y, Z and T to zero, holds done low and leaves cmd_ready high.
- R2: A command is taken only on a clock edge where cmd_valid and cmd_ready are both high, and cmd_ready is low in every cycle after that until the command's done cycle.
- R3: A two-operand command taken in cycle n loads T from the left source in cycle n+1, writes T op right-source into the destination in cycle n+2, and raises done in cycle n+3, the same cycle cmd_ready returns high.
- R4: Opcode 0 is ADD modulo 2^16, 1 is bitwise AND, 2 is bitwise OR, and 3 is bitwise NOT of the right operand; the left operand is always T.
- R5: Opcode 3 finishes in one control step: done rises in cycle n+2, T keeps its value, and the left source field has no effect.
- R6: A register may be both a source and the destination; the operation reads its old value and the new value appears only after the write edge.
- R7: Select code 0 names X, 1 names Y and 2 names Z; source code 3 puts zero on the bus, and destination code 3 discards the result (done still pulses).
- R8: done is high for exactly one cycle per command, and X, Y, Z change only on the edge that raises done.
- R9: cmd_valid and the command fields have no effect while cmd_ready is low.
- R10: At most one register drives the read bus in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_src_a | input | 2 | Left operand select (copied into T) |
| cmd_src_b | input | 2 | Right operand select (driven on the read bus in the compute step) |
| cmd_dst | input | 2 | Destination select |
| cmd_op | input | 2 | ALU opcode |
| done | output | 1 | One-cycle pulse after the write step |
| regs_out | output | 48 | X in [15:0], Y in [31:16], Z in [47:32] |
| t_out | output | 16 | Contents of the temporary register T |

## Verification
The properties assume that reset is held for at least one edge before any command and that inputs settle away from the clock edge. They place no limits on the command fields, so codes 3 in every select and opcode position are legal. The stimulus keeps cmd_valid high with random fields while the sequencer is busy, so the property that ready stays low and the comparison of register contents both see whether busy-time commands leak in.

// File: rtl/twobus_pkg.sv
package twobus_pkg;

   typedef enum logic [1:0] {
      OP_ADD  = 2'd0,
      OP_AND  = 2'd1,
      OP_OR   = 2'd2,
      OP_NOTB = 2'd3
   } alu_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_EXEC = 2'd2
   } seq_state_e;

   function automatic logic op_is_monadic(alu_op_e op);
      return op == OP_NOTB;
   endfunction

endpackage

// File: rtl/twobus_regs.sv
module twobus_regs #(
   parameter int DW   = 16,
   parameter int NREG = 3
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NREG-1:0]      wr_oh,
   input  logic [DW-1:0]        wr_data,
   input  logic                 t_load,
   input  logic [DW-1:0]        t_data,
   output logic [NREG*DW-1:0]   regs_flat,
   output logic [DW-1:0]        t_q
);

   genvar gi;
   generate
      for (gi = 0; gi < NREG; gi++) begin : g_store
         logic [DW-1:0] word_q;
         always_ff @(posedge clk) begin
            if (rst)
               word_q <= '0;
            else if (wr_oh[gi])
               word_q <= wr_data;
         end
         assign regs_flat[gi*DW +: DW] = word_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         t_q <= '0;
      else if (t_load)
         t_q <= t_data;
   end

endmodule

// File: rtl/twobus_rbus.sv
module twobus_rbus #(
   parameter int DW         = 16,
   parameter int NREG       = 3,
   parameter int SELW       = 2,
   parameter bit ONEHOT_BUS = 1'b1
) (
   input  logic [SELW-1:0]      sel,
   input  logic [NREG*DW-1:0]   regs_flat,
   output logic [NREG-1:0]      sel_oh,
   output logic [DW-1:0]        bus
);

   genvar gi;
   generate
      for (gi = 0; gi < NREG; gi++) begin : g_dec
         assign sel_oh[gi] = (sel == SELW'(gi));
      end

      if (ONEHOT_BUS) begin : g_andor
         always_comb begin
            bus = '0;
            for (int i = 0; i < NREG; i++)
               bus = bus | (regs_flat[i*DW +: DW] & {DW{sel_oh[i]}});
         end
      end else begin : g_index
         always_comb begin
            bus = '0;
            for (int i = 0; i < NREG; i++)
               if (sel == SELW'(i))
                  bus = regs_flat[i*DW +: DW];
         end
      end
   endgenerate

endmodule

// File: rtl/twobus_alu.sv
module twobus_alu
   import twobus_pkg::*;
#(
   parameter int DW = 16
) (
   input  alu_op_e        op,
   input  logic [DW-1:0]  lhs,
   input  logic [DW-1:0]  rhs,
   output logic [DW-1:0]  result
);

   always_comb begin
      unique case (op)
         OP_ADD:  result = lhs + rhs;
         OP_AND:  result = lhs & rhs;
         OP_OR:   result = lhs | rhs;
         OP_NOTB: result = ~rhs;
         default: result = '0;
      endcase
   end

endmodule

// File: rtl/twobus_ctrl.sv
module twobus_ctrl
   import twobus_pkg::*;
#(
   parameter int NREG = 3,
   parameter int SELW = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cmd_valid,
   input  logic [SELW-1:0]  cmd_src_a,
   input  logic [SELW-1:0]  cmd_src_b,
   input  logic [SELW-1:0]  cmd_dst,
   input  logic [1:0]       cmd_op,
   output logic             cmd_ready,
   output logic [SELW-1:0]  rd_sel,
   output logic             t_load,
   output logic [NREG-1:0]  wr_oh,
   output alu_op_e          alu_op,
   output logic             done
);

   localparam logic [SELW-1:0] SEL_NONE = '1;

   seq_state_e       state_q;
   logic [SELW-1:0]  src_a_q, src_b_q, dst_q;
   alu_op_e          op_q;
   logic             done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         src_a_q <= '0;
         src_b_q <= '0;
         dst_q   <= '0;
         op_q    <= OP_ADD;
         done_q  <= 1'b0;
      end else begin
         done_q <= (state_q == ST_EXEC);
         unique case (state_q)
            ST_IDLE: begin
               if (cmd_valid) begin
                  src_a_q <= cmd_src_a;
                  src_b_q <= cmd_src_b;
                  dst_q   <= cmd_dst;
                  op_q    <= alu_op_e'(cmd_op);
                  state_q <= op_is_monadic(alu_op_e'(cmd_op)) ? ST_EXEC : ST_LOAD;
               end
            end
            ST_LOAD: state_q <= ST_EXEC;
            ST_EXEC: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (state_q)
         ST_LOAD: rd_sel = src_a_q;
         ST_EXEC: rd_sel = src_b_q;
         default: rd_sel = SEL_NONE;
      endcase
   end

   genvar gi;
   generate
      for (gi = 0; gi < NREG; gi++) begin : g_wr
         assign wr_oh[gi] = (state_q == ST_EXEC) && (dst_q == SELW'(gi));
      end
   endgenerate

   assign t_load    = (state_q == ST_LOAD);
   assign alu_op    = op_q;
   assign cmd_ready = (state_q == ST_IDLE);
   assign done      = done_q;

endmodule

// File: rtl/twobus_seq.sv
module twobus_seq
   import twobus_pkg::*;
#(
   parameter int DW         = 16,
   parameter int NREG       = 3,
   parameter bit ONEHOT_BUS = 1'b1,
   localparam int SELW      = $clog2(NREG + 1)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                cmd_valid,
   output logic                cmd_ready,
   input  logic [SELW-1:0]     cmd_src_a,
   input  logic [SELW-1:0]     cmd_src_b,
   input  logic [SELW-1:0]     cmd_dst,
   input  logic [1:0]          cmd_op,
   output logic                done,
   output logic [NREG*DW-1:0]  regs_out,
   output logic [DW-1:0]       t_out
);

   generate
      if (DW < 2) begin : g_bad_dw
         $error("twobus_seq: DW must be at least 2");
      end
      if (NREG < 2) begin : g_bad_nreg
         $error("twobus_seq: NREG must be at least 2");
      end
   endgenerate

   logic [SELW-1:0]  rd_sel;
   logic [NREG-1:0]  rd_oh;
   logic [DW-1:0]    rd_bus;
   logic [DW-1:0]    wr_bus;
   logic [NREG-1:0]  wr_oh;
   logic             t_load;
   alu_op_e          alu_op;

   twobus_ctrl #(.NREG(NREG), .SELW(SELW)) i_ctrl (
      .clk       (clk),
      .rst       (rst),
      .cmd_valid (cmd_valid),
      .cmd_src_a (cmd_src_a),
      .cmd_src_b (cmd_src_b),
      .cmd_dst   (cmd_dst),
      .cmd_op    (cmd_op),
      .cmd_ready (cmd_ready),
      .rd_sel    (rd_sel),
      .t_load    (t_load),
      .wr_oh     (wr_oh),
      .alu_op    (alu_op),
      .done      (done)
   );

   twobus_rbus #(.DW(DW), .NREG(NREG), .SELW(SELW), .ONEHOT_BUS(ONEHOT_BUS)) i_rbus (
      .sel       (rd_sel),
      .regs_flat (regs_out),
      .sel_oh    (rd_oh),
      .bus       (rd_bus)
   );

   twobus_alu #(.DW(DW)) i_alu (
      .op     (alu_op),
      .lhs    (t_out),
      .rhs    (rd_bus),
      .result (wr_bus)
   );

   twobus_regs #(.DW(DW), .NREG(NREG)) i_regs (
      .clk       (clk),
      .rst       (rst),
      .wr_oh     (wr_oh),
      .wr_data   (wr_bus),
      .t_load    (t_load),
      .t_data    (rd_bus),
      .regs_flat (regs_out),
      .t_q       (t_out)
   );

endmodule

// File: rtl/twobus_seq_chk.sv
module twobus_seq_chk #(
   parameter int DW   = 16,
   parameter int NREG = 3,
   parameter int SELW = 2
) (
   input logic                clk,
   input logic                rst,
   input logic                cmd_valid,
   input logic                cmd_ready,
   input logic [1:0]          cmd_op,
   input logic                done,
   input logic [NREG*DW-1:0]  regs_out,
   input logic [DW-1:0]       t_out,
   input logic [NREG-1:0]     rd_oh
);

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
      cmd_valid && cmd_ready |=> !cmd_ready);                                  // R2

   AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
      done |-> cmd_ready);                                                     // R3

   AST_NOT_KEEPS_T: assert property (@(posedge clk) disable iff (rst)
      cmd_valid && cmd_ready && (cmd_op == 2'd3) |=> $stable(t_out) ##1 $stable(t_out)); // R5

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);                                                         // R8

   AST_WRITE_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && !$stable(regs_out) |-> done);                             // R8

   AST_ONE_BUS_DRIVER: assert property (@(posedge clk) disable iff (rst)
      $onehot0(rd_oh));                                                        // R10

endmodule

bind twobus_seq twobus_seq_chk #(.DW(DW), .NREG(NREG), .SELW(SELW)) i_chk (
   .clk       (clk),
   .rst       (rst),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_op    (cmd_op),
   .done      (done),
   .regs_out  (regs_out),
   .t_out     (t_out),
   .rd_oh     (rd_oh)
);

// File: tb/test_twobus_seq.sv
module test_twobus_seq;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [1:0]  cmd_src_a = '0, cmd_src_b = '0, cmd_dst = '0, cmd_op = '0;
   logic        done;
   logic [47:0] regs_out;
   logic [15:0] t_out;

   always #2 clk = ~clk;   // 250 MHz

   twobus_seq i_twobus_seq (
      .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b), .cmd_dst(cmd_dst),
      .cmd_op(cmd_op), .done(done), .regs_out(regs_out), .t_out(t_out)
   );

   typedef struct {
      logic [47:0] regs;
      logic [15:0] t;
      int          acc;
      int          lat;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   int          checks = 0;
   int          fails  = 0;
   int          cyc    = 0;
   logic [15:0] m [0:2];
   logic [15:0] mt;
   logic [47:0] prev_regs;
   logic        prev_done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] rd(logic [1:0] s);
      return (s == 2'd3) ? 16'h0 : m[s];
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 3; i++) m[i] = '0;
      mt = '0;
   endtask

   // Driver: called at a negedge; returns at the negedge of the done cycle.
   task automatic issue(logic [1:0] op, logic [1:0] a, logic [1:0] b,
                        logic [1:0] d, bit noisy, string tag);
      exp_t        e;
      logic [15:0] res;
      cmd_valid = 1'b1; cmd_op = op; cmd_src_a = a; cmd_src_b = b; cmd_dst = d;
      while (!cmd_ready) @(negedge clk);
      if (op == 2'd3) begin
         res = ~rd(b);
      end else begin
         mt = rd(a);
         case (op)
            2'd0:    res = mt + rd(b);
            2'd1:    res = mt & rd(b);
            default: res = mt | rd(b);
         endcase
      end
      if (d != 2'd3) m[d] = res;
      e.regs = {m[2], m[1], m[0]};
      e.t    = mt;
      e.acc  = cyc;
      e.lat  = (op == 2'd3) ? 2 : 3;
      e.tag  = tag;
      sb.push_back(e);
      @(negedge clk);
      check(cmd_ready == 1'b0, "R2", "ready after accept", 64'(cmd_ready), 64'd0);
      if (noisy) begin   // R9: junk commands while busy
         cmd_valid = 1'b1;
         cmd_op = 2'($urandom_range(0, 3));
         cmd_src_a = 2'($urandom_range(0, 3));
         cmd_src_b = 2'($urandom_range(0, 3));
         cmd_dst = 2'($urandom_range(0, 3));
      end else begin
         cmd_valid = 1'b0;
      end
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (!rst) begin
         if (done) begin
            if (sb.size() == 0) begin
               check(1'b0, "R8", "unexpected done", 64'd1, 64'd0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(regs_out == e.regs, e.tag, "regs", 64'(regs_out), 64'(e.regs));
               check(t_out == e.t, e.tag, "T", 64'(t_out), 64'(e.t));
               check(cyc - e.acc == e.lat, e.tag, "latency", 64'(cyc - e.acc), 64'(e.lat));
            end
            if (prev_done)
               check(1'b0, "R8", "done width", 64'd2, 64'd1);
         end else if (regs_out !== prev_regs) begin
            check(1'b0, "R8", "regs moved without done", 64'(regs_out), 64'(prev_regs));
         end
      end
      prev_regs = regs_out;
      prev_done = done;
   end

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      cmd_valid = 1'b1;   // ignored under reset
      repeat (3) @(negedge clk);
      rst = 1'b0;
      cmd_valid = 1'b0;
      model_reset();
      check(regs_out == '0, "R1", "regs after reset", 64'(regs_out), 64'd0);
      check(t_out == '0, "R1", "T after reset", 64'(t_out), 64'd0);
      check(cmd_ready == 1'b1, "R1", "ready after reset", 64'(cmd_ready), 64'd1);
      check(done == 1'b0, "R1", "done after reset", 64'(done), 64'd0);
   endtask

   initial begin
      model_reset();
      do_reset();
      issue(2'd3, 2'd2, 2'd1, 2'd0, 0, "R5");   // X = ~Y, T untouched
      issue(2'd0, 2'd0, 2'd0, 2'd1, 0, "R4");   // Y = X + X
      issue(2'd0, 2'd1, 2'd0, 2'd2, 0, "R3");   // Z = Y + X (wraps)
      issue(2'd1, 2'd2, 2'd1, 2'd0, 1, "R4");   // X = Z & Y
      issue(2'd2, 2'd0, 2'd2, 2'd1, 1, "R4");   // Y = X | Z
      issue(2'd0, 2'd0, 2'd1, 2'd0, 0, "R6");   // X = X + Y
      issue(2'd1, 2'd2, 2'd2, 2'd2, 0, "R6");   // Z = Z & Z
      issue(2'd0, 2'd0, 2'd3, 2'd2, 0, "R7");   // Z = X + 0
      issue(2'd3, 2'd0, 2'd3, 2'd1, 0, "R7");   // Y = ~0
      issue(2'd2, 2'd1, 2'd0, 2'd3, 0, "R7");   // result discarded
      issue(2'd3, 2'd1, 2'd2, 2'd0, 1, "R9");
      for (int k = 0; k < 60; k++)
         issue(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
               2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 1, "R9");
      repeat (3) @(negedge clk);
      check(sb.size() == 0, "R3", "pending results", 64'(sb.size()), 64'd0);
      do_reset();
      issue(2'd3, 2'd0, 2'd0, 2'd2, 0, "R5");
      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired expected=finish actual=hang");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule